// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register with Collision Test

This block is the basic control register of a 10/100 Ethernet PHY as seen from the management side. A management front end that has already decoded the serial frames presents a register address, write data and a write strobe, and it reads back the register contents combinationally. Of the sixteen bits, the upper nine are stored control bits and the lowest seven form a reserved field that always reads as zero. The stored bits are loopback (bit 14), auto-negotiation enable (bit 12), manual duplex (bit 8) and collision test enable (bit 7). The other upper bits are kept as plain storage for neighbouring logic.

The block resolves the duplex mode the PHY runs in. Loopback forces full duplex. Otherwise a set auto-negotiation enable takes the negotiated result from an input. With auto-negotiation off, the manual duplex bit decides. The collision test generator echoes the MAC transmit enable onto the collision output. The delays are counted in pulses of an external bit-time clock enable. The echo works whether or not loopback is on.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After reset the control register at address 0 reads 0x1000: only auto-negotiation enable (bit 12) is set, and the collision output is low.
- R2: Bits 6..0 of the control register always read 0, and a write of ones to them leaves them reading 0.
- R3: A write strobe with address 0 stores write data bits 15..7, which read back from the next cycle on. A write to any other address changes nothing, and a read of any other address returns 0.
- R4: With loopback (bit 14) clear and auto-negotiation enable (bit 12) set, the duplex output equals the negotiated duplex input, and bit 8 has no effect.
- R5: With bits 14 and 12 clear, the duplex output equals bit 8 (1 full, 0 half), and the negotiated input has no effect.
- R6: With loopback (bit 14) set, the duplex output is 1 (full), whatever bit 8 and the negotiated input hold.
- R7: While collision test (bit 7) is clear, the collision output stays low whatever the transmit enable does.
- R8: With bit 7 set, the transmit enable is first seen high in some cycle. The collision output then rises with the 64th bit-time enable seen in the cycles after it. Cycles without an enable do not count.
- R9: If the transmit enable falls before the 64th enable, the pending rise is dropped, the collision output stays low, and the next rise of the transmit enable starts a fresh count.
- R10: With the collision output high, the transmit enable is first seen low in some cycle. The collision output falls with the 2nd bit-time enable seen in the cycles after it.
- R11: The collision echo of R8 and R10 works the same with loopback set.
- R12: Clearing bit 7 while the collision output is high (or about to rise) drives it low one cycle after the write is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| mgmt_addr | input | 5 | Register address from the management front end |
| mgmt_wdata | input | 16 | Write data |
| mgmt_we | input | 1 | Write strobe |
| mgmt_rdata | output | 16 | Read data for the addressed register |
| neg_full_duplex | input | 1 | Negotiated duplex result, 1 = full |
| tx_en | input | 1 | MAC transmit enable |
| full_duplex | output | 1 | Effective duplex mode, 1 = full |
| col | output | 1 | Collision output |

## Verification
A register write that clears collision test can be captured on the same clock edge at which the collision output would rise. The bench provokes this by raising the transmit enable and timing a write of bit 7 = 0 so that it lands on the 64th counted enable. The expected result is that the rise still takes effect for exactly one cycle, since the generator sees the old enable value at that edge, and that the output is low on the following cycle. The scoreboard holds the expected collision values for both of those cycles. The same run has loopback set, so the duplex forcing and the collision echo are also checked side by side.

// File: rtl/phy_ctrl_pkg.sv
// Package: shared constants and types for the PHY basic control register.
// Assumes a 16-bit management register with a 7-bit reserved field at the bottom.
package phy_ctrl_pkg;
    localparam int CTRL_DATA_W  = 16;
    localparam int CTRL_ADDR_W  = 5;
    localparam int CTRL_RSVD_W  = 7;
    localparam int CTRL_ADDR    = 0;
    localparam int POS_LOOP     = 14;
    localparam int POS_AN_EN    = 12;
    localparam int POS_MAN_DUP  = 8;
    localparam int POS_COLTEST  = 7;
    localparam logic [CTRL_DATA_W-1:0] CTRL_RESET = 16'h1000;

    typedef enum logic [1:0] {
        CT_IDLE = 2'd0,
        CT_ARM  = 2'd1,
        CT_ON   = 2'd2,
        CT_HOLD = 2'd3
    } col_state_e;
endpackage

// File: rtl/phy_ctrl_regfile.sv
// Module: storage of the control register's upper bits and its read path.
// Assumes a single-cycle write strobe. Reads are combinational and the reserved
// field is never stored, so it always reads zero.
module phy_ctrl_regfile
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W   = CTRL_ADDR_W,
    parameter int DATA_W   = CTRL_DATA_W,
    parameter int RSVD_W   = CTRL_RSVD_W,
    parameter int REG_ADDR = CTRL_ADDR,
    parameter logic [DATA_W-1:0] RESET_VAL = CTRL_RESET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic [DATA_W-1:0] rdata,
    output logic              loop_o,
    output logic              an_en_o,
    output logic              man_dup_o,
    output logic              coltest_o
);
    localparam int STORE_W = DATA_W - RSVD_W;
    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

    logic [STORE_W-1:0] ctrl_q;
    logic               hit;

    // Decode whether the front end addresses this register.
    always_comb hit = (addr == SEL);

    // Capture the stored bits on a write to this register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= RESET_VAL[DATA_W-1:RSVD_W];
        else if (we && hit)
            ctrl_q <= wdata[DATA_W-1:RSVD_W];
    end

    // Build the read data: stored bits above a zero reserved field.
    always_comb rdata = hit ? {ctrl_q, {RSVD_W{1'b0}}} : '0;

    // Hand the decoded control bits to the neighbouring logic.
    always_comb begin
        loop_o    = ctrl_q[POS_LOOP    - RSVD_W];
        an_en_o   = ctrl_q[POS_AN_EN   - RSVD_W];
        man_dup_o = ctrl_q[POS_MAN_DUP - RSVD_W];
        coltest_o = ctrl_q[POS_COLTEST - RSVD_W];
    end

    // R3: a captured write is visible on the next cycle's read path.
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit) |=> (rdata[DATA_W-1:RSVD_W] == $past(wdata[DATA_W-1:RSVD_W])));

    // R2: the reserved field never reads nonzero.
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[RSVD_W-1:0] == '0);
endmodule

// File: rtl/phy_duplex_sel.sv
// Module: resolves the effective duplex mode.
// Priority is loopback (forces full), then auto-negotiation result, then the manual bit.
// Assumes all inputs are synchronous to the register clock.
module phy_duplex_sel (
    input  logic loop_i,
    input  logic an_en_i,
    input  logic man_dup_i,
    input  logic neg_dup_i,
    output logic full_dup_o
);
    // Pick the duplex source by priority.
    always_comb begin
        if (loop_i)
            full_dup_o = 1'b1;
        else if (an_en_i)
            full_dup_o = neg_dup_i;
        else
            full_dup_o = man_dup_i;
    end
endmodule

// File: rtl/phy_col_test.sv
// Module: collision test generator. It echoes the transmit enable onto the collision output
// after ON_DLY bit-time enables and drops it OFF_DLY enables after the transmit enable falls.
// Assumes bit_tick is a one-cycle pulse and that tx_en is synchronous.
module phy_col_test
    import phy_ctrl_pkg::*;
#(
    parameter int ON_DLY  = 64,
    parameter int OFF_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic bit_tick,
    input  logic tx_en,
    output logic col_o
);
    localparam int MAX_DLY = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_DLY - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_DLY - 1);

    col_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and counter logic of the echo sequencer.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable_i) begin
            state_d = CT_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CT_IDLE: begin
                    if (tx_en) begin
                        state_d = CT_ARM;
                        cnt_d   = '0;
                    end
                end
                CT_ARM: begin
                    if (!tx_en) begin
                        state_d = CT_IDLE;
                        cnt_d   = '0;
                    end else if (bit_tick) begin
                        if (cnt_q == ON_LAST) begin
                            state_d = CT_ON;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                CT_ON: begin
                    if (!tx_en) begin
                        state_d = CT_HOLD;
                        cnt_d   = '0;
                    end
                end
                CT_HOLD: begin
                    if (tx_en) begin
                        state_d = CT_ON;
                        cnt_d   = '0;
                    end else if (bit_tick) begin
                        if (cnt_q == OFF_LAST) begin
                            state_d = CT_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = CT_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered collision output, high while echoing or holding after the fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            col_o <= 1'b0;
        else
            col_o <= enable_i && ((state_d == CT_ON) || (state_d == CT_HOLD));
    end

    // R7, R12: a disabled generator leaves the output low on the next cycle.
    assert_off_forces_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !col_o);

    // R9: a transmit enable that drops while arming keeps the output low.
    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CT_ARM && !tx_en) |=> !col_o);

    // R8: the output only rises when transmit enable and the test were both active.
    assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_o) |-> $past(tx_en && enable_i && bit_tick));

    // R10: the output only falls after transmit enable went low or the test was cleared.
    assert_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(col_o) |-> $past(!tx_en || !enable_i));
endmodule

// File: rtl/phy_ctrl_reg.sv
// Module: top of the PHY basic control register. It joins the register storage,
// the duplex resolver and the collision test generator.
// Assumes a management front end that presents decoded register accesses.
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int ADDR_W    = CTRL_ADDR_W,
    parameter int DATA_W    = CTRL_DATA_W,
    parameter int COL_ON    = 64,
    parameter int COL_OFF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [ADDR_W-1:0] mgmt_addr,
    input  logic [DATA_W-1:0] mgmt_wdata,
    input  logic              mgmt_we,
    output logic [DATA_W-1:0] mgmt_rdata,
    input  logic              neg_full_duplex,
    input  logic              tx_en,
    output logic              full_duplex,
    output logic              col
);
    logic loop_bit, an_en_bit, man_dup_bit, coltest_bit;

    phy_ctrl_regfile #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RSVD_W   (CTRL_RSVD_W),
        .REG_ADDR (CTRL_ADDR),
        .RESET_VAL(CTRL_RESET)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (mgmt_addr),
        .wdata    (mgmt_wdata),
        .we       (mgmt_we),
        .rdata    (mgmt_rdata),
        .loop_o   (loop_bit),
        .an_en_o  (an_en_bit),
        .man_dup_o(man_dup_bit),
        .coltest_o(coltest_bit)
    );

    phy_duplex_sel u_dup (
        .loop_i    (loop_bit),
        .an_en_i   (an_en_bit),
        .man_dup_i (man_dup_bit),
        .neg_dup_i (neg_full_duplex),
        .full_dup_o(full_duplex)
    );

    phy_col_test #(
        .ON_DLY (COL_ON),
        .OFF_DLY(COL_OFF)
    ) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(coltest_bit),
        .bit_tick(bit_tick),
        .tx_en   (tx_en),
        .col_o   (col)
    );

    // R6: a write that sets loopback yields full duplex from the next cycle.
    assert_loop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && mgmt_addr == ADDR_W'(CTRL_ADDR) && mgmt_wdata[POS_LOOP]) |=> full_duplex);

    // R5: a write with loopback and auto-negotiation clear makes bit 8 the duplex.
    assert_manual_dup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && mgmt_addr == ADDR_W'(CTRL_ADDR) && !mgmt_wdata[POS_LOOP] && !mgmt_wdata[POS_AN_EN])
        |=> (full_duplex == $past(mgmt_wdata[POS_MAN_DUP])));
endmodule

// File: tb/phy_ctrl_reg_test.sv
module phy_ctrl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b1;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_we = 1'b0;
    logic [15:0] mgmt_rdata;
    logic        neg_full_duplex = 1'b0;
    logic        tx_en = 1'b0;
    logic        full_duplex;
    logic        col;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        int          kind;   // 0 col, 1 duplex, 2 read data
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    phy_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata), .mgmt_we(mgmt_we),
        .mgmt_rdata(mgmt_rdata), .neg_full_duplex(neg_full_duplex),
        .tx_en(tx_en), .full_duplex(full_duplex), .col(col)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop expected items whose cycle has come and compare away from the edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = {15'b0, col};
                    1:       act = {15'b0, full_duplex};
                    default: act = mgmt_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d kind %0d: actual %h expected %h",
                             it.req, cyc, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_at(input int ofs, input int kind, input logic [15:0] e, input string req);
        item_t it;
        it.at = cyc + ofs; it.kind = kind; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        step(1);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        mgmt_addr = a; mgmt_wdata = d; mgmt_we = 1'b1;
        step(1);
        mgmt_we = 1'b0; mgmt_addr = 5'd0;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    // Driver: apply stimulus and push the expected results.
    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state, R4 negotiated duplex followed
        expect_at(0, 2, 16'h1000, "R1");
        expect_at(0, 0, 16'h0, "R1");
        expect_at(0, 1, 16'h0, "R4");
        drain();
        neg_full_duplex = 1'b1;
        expect_at(0, 1, 16'h1, "R4");
        drain();
        wr(5'd0, 16'h1000);  // bit 8 = 0 under auto-negotiation
        expect_at(0, 1, 16'h1, "R4");
        drain();
        // R2, R3 write and readback, reserved bits stay zero; R5 manual full
        neg_full_duplex = 1'b0;
        wr(5'd0, 16'hA57F);
        expect_at(0, 2, 16'hA500, "R2");
        expect_at(0, 1, 16'h1, "R5");
        drain();
        neg_full_duplex = 1'b1;
        wr(5'd0, 16'h0000);
        expect_at(0, 1, 16'h0, "R5");
        expect_at(0, 2, 16'h0000, "R3");
        drain();
        // R3 other address ignored and reads zero
        wr(5'd5, 16'hFFFF);
        expect_at(0, 2, 16'h0000, "R3");
        drain();
        mgmt_addr = 5'd5;
        expect_at(0, 2, 16'h0000, "R3");
        drain();
        mgmt_addr = 5'd0;
        // R6 loopback forces full duplex
        neg_full_duplex = 1'b0;
        wr(5'd0, 16'h4000);
        expect_at(0, 1, 16'h1, "R6");
        drain();
        wr(5'd0, 16'h5000);
        expect_at(0, 1, 16'h1, "R6");
        drain();
        wr(5'd0, 16'h0000);
        // R7 collision test off: no echo
        tx_en = 1'b1;
        expect_at(70, 0, 16'h0, "R7");
        drain();
        tx_en = 1'b0;
        step(4);
        // R8 rise timing, R10 fall timing
        wr(5'd0, 16'h0080);
        tx_en = 1'b1;
        expect_at(64, 0, 16'h0, "R8");
        expect_at(65, 0, 16'h1, "R8");
        drain();
        tx_en = 1'b0;
        expect_at(2, 0, 16'h1, "R10");
        expect_at(3, 0, 16'h0, "R10");
        drain();
        // R9 early drop cancels, then a fresh count
        tx_en = 1'b1;
        step(30);
        tx_en = 1'b0;
        expect_at(0, 0, 16'h0, "R9");
        expect_at(50, 0, 16'h0, "R9");
        drain();
        tx_en = 1'b1;
        expect_at(64, 0, 16'h0, "R9");
        expect_at(65, 0, 16'h1, "R9");
        drain();
        tx_en = 1'b0;
        step(6);
        // R8 only bit-time enables count
        bit_tick = 1'b0;
        tx_en = 1'b1;
        expect_at(100, 0, 16'h0, "R8");
        drain();
        bit_tick = 1'b1;
        expect_at(63, 0, 16'h0, "R8");
        expect_at(64, 0, 16'h1, "R8");
        drain();
        tx_en = 1'b0;
        expect_at(2, 0, 16'h1, "R10");
        expect_at(3, 0, 16'h0, "R10");
        drain();
        // R11 echo in loopback, R12 clear while high
        wr(5'd0, 16'h4080);
        tx_en = 1'b1;
        expect_at(64, 0, 16'h0, "R11");
        expect_at(65, 0, 16'h1, "R11");
        expect_at(65, 1, 16'h1, "R6");
        drain();
        wr(5'd0, 16'h4000);
        expect_at(0, 0, 16'h1, "R12");
        expect_at(1, 0, 16'h0, "R12");
        expect_at(20, 0, 16'h0, "R7");
        drain();
        tx_en = 1'b0;
        step(4);
        // R12 clear captured on the same edge as the rise
        wr(5'd0, 16'h4080);
        tx_en = 1'b1;
        expect_at(64, 0, 16'h0, "R12");
        expect_at(65, 0, 16'h1, "R12");
        expect_at(66, 0, 16'h0, "R12");
        step(64);
        wr(5'd0, 16'h4000);
        drain();
        tx_en = 1'b0;
        step(4);
        done = 1'b1;
        report();
    end
endmodule